// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one outgoing low-speed USB packet onto the differential D+/D- pair. A packet is started by one of three one-cycle requests: a data packet whose length (sync byte included) is given alongside the request, or a two-byte handshake, either an acknowledge or a negative acknowledge. The block first prepares the idle level, enables its drivers and holds idle for one bit. It then emits the sync byte and the payload least significant bit first, NRZI-coded, with a forced transition after every run of six ones. It closes with an end-of-packet sequence and gives the bus back. Payload bytes for data packets are pulled one at a time through a combinational fetch port.

Two side effects are tied to the moment the bus is released. A pending device address is copied into the active address register, but only when the packet just sent was a data packet. A flag that records receive-start events is cleared, because events seen during transmission are echoes of the block's own traffic.

Top module: `usbtx_ls_tx`

## Requirements
- R1: On an accepted request the block spends one clock with D- high, D+ low and drivers off. It then enables the drivers and holds that idle (J) level for one full bit time before the first sync bit.
- R2: The first byte sent is 0x80, followed by the packet bytes, each sent LSB first. A 0 bit is sent as a transition of both lines (J to K or K to J) and a 1 bit as no transition. J is D+=0/D-=1 and K is D+=1/D-=0.
- R3: Every bit, stuffed bits included, is held on the lines for exactly BIT_CLKS clocks (default 11).
- R4: After six consecutive 1 bits an extra transition (stuffed 0) is inserted. This applies across byte boundaries and after the final payload bit.
- R5: The data packet length counts the sync byte and is clamped into 2..12. Bytes 1..len-1 are fetched in order: `fetch_stb` pulses for one clock with `fetch_idx` set to the byte index, and `fetch_byte` is taken in that same clock.
- R6: An acknowledge request sends exactly sync then 0xD2, and a negative-acknowledge request sends exactly sync then 0x5A. Neither issues any fetch.
- R7: After the last bit the lines go to SE0 (both low) for two bit times, then J for one bit time. The drivers are then switched off with both lines low.
- R8: `busy` is high from the clock after an accepted request to the clock of bus release, 1 + BIT_CLKS*(bits+4) clocks in total, where bits counts data and stuffed bits. It is low after reset.
- R9: `dev_addr` takes the value of `new_addr` at bus release after a data packet only. It is unchanged by handshakes and is 0 after reset.
- R10: `rx_pend` is set by `rx_evt` and cleared at bus release. If `rx_evt` arrives in the release clock, the clear wins.
- R11: Requests arriving while `busy` is high are ignored. When several requests arrive together, data wins over acknowledge, which wins over negative acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_data | input | 1 | Start a data packet |
| req_ack | input | 1 | Start an acknowledge handshake |
| req_nak | input | 1 | Start a negative-acknowledge handshake |
| req_len | input | LEN_W | Data packet length including sync byte |
| fetch_stb | output | 1 | Payload byte taken this clock |
| fetch_idx | output | LEN_W | Index of the payload byte being fetched |
| fetch_byte | input | 8 | Payload byte at fetch_idx |
| new_addr | input | ADDR_W | Address to apply after the next data packet |
| dev_addr | output | ADDR_W | Active device address |
| rx_evt | input | 1 | Receive-start event |
| rx_pend | output | 1 | Receive-start event pending |
| usb_dp | output | 1 | D+ level |
| usb_dm | output | 1 | D- level |
| usb_oe | output | 1 | Line driver enable |
| busy | output | 1 | Transmission in progress |

## Verification
The release clock is where two functions meet: the pending-event flag is cleared while a new receive event may try to set it, and the address register may update. The bench raises `rx_evt` so that it is sampled exactly on the release edge. It then expects `rx_pend` low together with the new address after a data packet, or the old one after a handshake. A second overlap is a handshake request pulsed in the middle of a data packet. Here the bus-occupancy length and the decoded waveform must match a lone data packet.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ACQ,
        ST_SEND,
        ST_SE0,
        ST_EOPJ
    } tx_state_e;

    typedef enum logic [1:0] {
        PK_DATA,
        PK_ACK,
        PK_NAK
    } pkt_kind_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/usbtx_bittimer.sv
module usbtx_bittimer #(
    parameter int BIT_CLKS = 11,
    localparam int CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart) begin
            cnt_d = CNT_W'(BIT_CLKS - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);

endmodule

// File: rtl/usbtx_nrzi.sv
module usbtx_nrzi #(
    parameter int STUFF_RUN = 6,
    localparam int ONES_W = $clog2(STUFF_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic launch,
    input  logic bit_val,
    output logic level_k,
    output logic stuff_due
);

    typedef struct packed {
        logic              lvl;
        logic [ONES_W-1:0] ones;
    } nrzi_t;

    nrzi_t d, q;

    always_comb begin
        d = q;
        if (init) begin
            d.lvl  = 1'b0;
            d.ones = '0;
        end else if (launch) begin
            if (bit_val) begin
                d.ones = q.ones + ONES_W'(1);
            end else begin
                d.lvl  = ~q.lvl;
                d.ones = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_k   = q.lvl;
    assign stuff_due = (q.ones == ONES_W'(STUFF_RUN));

endmodule

// File: rtl/usbtx_linemap.sv
module usbtx_linemap
    import usbtx_pkg::*;
(
    input  tx_state_e state,
    input  logic      level_k,
    output logic      dp,
    output logic      dm,
    output logic      oe
);

    always_comb begin
        dp = 1'b0;
        dm = 1'b0;
        oe = 1'b0;
        unique case (state)
            ST_PREP: begin
                dm = 1'b1;
            end
            ST_ACQ, ST_EOPJ: begin
                oe = 1'b1;
                dm = 1'b1;
            end
            ST_SEND: begin
                oe = 1'b1;
                dp = level_k;
                dm = ~level_k;
            end
            ST_SE0: begin
                oe = 1'b1;
            end
            default: begin
                oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/usbtx_ls_tx.sv
module usbtx_ls_tx
    import usbtx_pkg::*;
#(
    parameter int BIT_CLKS  = 11,
    parameter int MIN_LEN   = 2,
    parameter int MAX_LEN   = 12,
    parameter int STUFF_RUN = 6,
    parameter int ADDR_W    = 7,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_data,
    input  logic              req_ack,
    input  logic              req_nak,
    input  logic [LEN_W-1:0]  req_len,
    output logic              fetch_stb,
    output logic [LEN_W-1:0]  fetch_idx,
    input  logic [7:0]        fetch_byte,
    input  logic [ADDR_W-1:0] new_addr,
    output logic [ADDR_W-1:0] dev_addr,
    input  logic              rx_evt,
    output logic              rx_pend,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              busy
);

    typedef struct packed {
        tx_state_e         state;
        pkt_kind_e         kind;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  bidx;
        logic [7:0]        shreg;
        logic [2:0]        bitn;
        logic              last;
        logic              se0_two;
        logic [ADDR_W-1:0] addr;
        logic              rxp;
    } ctl_t;

    ctl_t n, q;

    logic tick, tmr_restart;
    logic nz_init, nz_launch, nz_bit, level_k, stuff_due;
    logic adv;
    logic [LEN_W-1:0] len_clamped;

    usbtx_bittimer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (tick)
    );

    usbtx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (nz_init),
        .launch    (nz_launch),
        .bit_val   (nz_bit),
        .level_k   (level_k),
        .stuff_due (stuff_due)
    );

    usbtx_linemap u_lines (
        .state   (q.state),
        .level_k (level_k),
        .dp      (usb_dp),
        .dm      (usb_dm),
        .oe      (usb_oe)
    );

    always_comb begin
        if (req_len < LEN_W'(MIN_LEN))      len_clamped = LEN_W'(MIN_LEN);
        else if (req_len > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
        else                                len_clamped = req_len;
    end

    assign fetch_idx = q.bidx + LEN_W'(1);

    always_comb begin
        n           = q;
        tmr_restart = 1'b0;
        nz_init     = 1'b0;
        nz_launch   = 1'b0;
        nz_bit      = 1'b1;
        fetch_stb   = 1'b0;
        adv         = 1'b0;

        if (rx_evt) n.rxp = 1'b1;

        unique case (q.state)
            ST_IDLE: begin
                if (req_data || req_ack || req_nak) begin
                    n.state   = ST_PREP;
                    n.shreg   = SYNC_BYTE;
                    n.bitn    = '0;
                    n.bidx    = '0;
                    n.last    = 1'b0;
                    n.se0_two = 1'b0;
                    nz_init   = 1'b1;
                    if (req_data) begin
                        n.kind = PK_DATA;
                        n.len  = len_clamped;
                    end else if (req_ack) begin
                        n.kind = PK_ACK;
                        n.len  = LEN_W'(2);
                    end else begin
                        n.kind = PK_NAK;
                        n.len  = LEN_W'(2);
                    end
                end
            end
            ST_PREP: begin
                n.state     = ST_ACQ;
                tmr_restart = 1'b1;
            end
            ST_ACQ, ST_SEND: begin
                adv = tick;
            end
            ST_SE0: begin
                if (tick) begin
                    tmr_restart = 1'b1;
                    if (!q.se0_two) n.se0_two = 1'b1;
                    else            n.state   = ST_EOPJ;
                end
            end
            ST_EOPJ: begin
                if (tick) begin
                    n.state = ST_IDLE;
                    n.rxp   = 1'b0;
                    if (q.kind == PK_DATA) n.addr = new_addr;
                end
            end
            default: begin
                n.state = ST_IDLE;
            end
        endcase

        if (adv) begin
            tmr_restart = 1'b1;
            if (stuff_due) begin
                nz_launch = 1'b1;
                nz_bit    = 1'b0;
                n.state   = ST_SEND;
            end else if (!q.last) begin
                nz_launch = 1'b1;
                nz_bit    = q.shreg[0];
                n.state   = ST_SEND;
                if (q.bitn == 3'd7) begin
                    n.bitn = '0;
                    if (q.bidx + LEN_W'(1) == q.len) begin
                        n.last = 1'b1;
                    end else begin
                        n.bidx = q.bidx + LEN_W'(1);
                        unique case (q.kind)
                            PK_DATA: begin
                                fetch_stb = 1'b1;
                                n.shreg   = fetch_byte;
                            end
                            PK_ACK:  n.shreg = PID_ACK;
                            default: n.shreg = PID_NAK;
                        endcase
                    end
                end else begin
                    n.bitn  = q.bitn + 3'd1;
                    n.shreg = {1'b0, q.shreg[7:1]};
                end
            end else begin
                n.state = ST_SE0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.kind  <= PK_DATA;
        end else begin
            q <= n;
        end
    end

    assign busy     = (q.state != ST_IDLE);
    assign dev_addr = q.addr;
    assign rx_pend  = q.rxp;

endmodule

// File: rtl/usbtx_ls_tx_chk.sv
module usbtx_ls_tx_chk #(
    parameter int BIT_CLKS = 11,
    parameter int ADDR_W   = 7,
    localparam int PH_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usb_dp,
    input logic              usb_dm,
    input logic              usb_oe,
    input logic              busy,
    input logic              fetch_stb,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              rx_pend
);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               phase_q <= '0;
        else if (!usb_oe)                         phase_q <= '0;
        else if (phase_q == PH_W'(BIT_CLKS - 1))  phase_q <= '0;
        else                                      phase_q <= phase_q + PH_W'(1);
    end

    // R1
    idle_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!usb_oe && usb_dm && !usb_dp));

    // R1
    drive_starts_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_oe) |-> (usb_dm && !usb_dp));

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_oe && phase_q != '0) |-> $stable({usb_dp, usb_dm}));

    // R7
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(usb_oe) |-> (!usb_dp && !usb_dm));

    // R7
    release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(usb_oe) |-> ($past(usb_dm) && !$past(usb_dp)));

    // R8
    no_drive_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !usb_oe);

    // R9
    addr_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(dev_addr));

    // R10
    pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !rx_pend);

    // R5
    fetch_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> (busy && usb_oe));

endmodule

bind usbtx_ls_tx usbtx_ls_tx_chk #(.BIT_CLKS(BIT_CLKS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .usb_dp    (usb_dp),
    .usb_dm    (usb_dm),
    .usb_oe    (usb_oe),
    .busy      (busy),
    .fetch_stb (fetch_stb),
    .dev_addr  (dev_addr),
    .rx_pend   (rx_pend)
);

// File: tb/sim_usbtx_ls_tx.sv
module sim_usbtx_ls_tx;

    localparam int BITC = 11;
    localparam int CAPN = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_data = 1'b0, req_ack = 1'b0, req_nak = 1'b0;
    logic [3:0] req_len = '0;
    logic       fetch_stb;
    logic [3:0] fetch_idx;
    logic [7:0] fetch_byte;
    logic [6:0] new_addr = '0;
    logic [6:0] dev_addr;
    logic       rx_evt = 1'b0;
    logic       rx_pend;
    logic       usb_dp, usb_dm, usb_oe, busy;

    logic [7:0] pkt [0:15];
    int         exp_sym [0:255];
    int         cap [0:CAPN-1];
    int         tests = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    always_comb fetch_byte = pkt[fetch_idx];

    usbtx_ls_tx u0 (
        .clk(clk), .rst_n(rst_n),
        .req_data(req_data), .req_ack(req_ack), .req_nak(req_nak), .req_len(req_len),
        .fetch_stb(fetch_stb), .fetch_idx(fetch_idx), .fetch_byte(fetch_byte),
        .new_addr(new_addr), .dev_addr(dev_addr),
        .rx_evt(rx_evt), .rx_pend(rx_pend),
        .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe), .busy(busy)
    );

    // kind[23:20] len[19:16] pattern[15:8] step[7:0]; kind 0 data, 1 ack, 2 nak
    localparam logic [23:0] VEC [8] = '{
        24'h0_4_12_35,
        24'h0_3_FF_00,
        24'h0_2_FC_00,
        24'h1_2_00_00,
        24'h2_2_00_00,
        24'h0_C_A5_1F,
        24'h0_F_00_00,
        24'h0_0_7E_00
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 J driven, 1 K driven, 2 SE0 driven, 4 J prepared undriven, 5 released low, 3 other
    function automatic int symcode();
        if (usb_oe && !usb_dp && usb_dm)  return 0;
        if (usb_oe && usb_dp && !usb_dm)  return 1;
        if (usb_oe && !usb_dp && !usb_dm) return 2;
        if (!usb_oe && !usb_dp && usb_dm) return 4;
        if (!usb_oe && !usb_dp && !usb_dm) return 5;
        return 3;
    endfunction

    function automatic int build(input int kind, input int n);
        int k = 0, lev = 0, ones = 0;
        logic [7:0] b;
        exp_sym[k++] = 0;
        for (int bi = 0; bi < n; bi++) begin
            if (bi == 0)        b = 8'h80;
            else if (kind == 1) b = 8'hD2;
            else if (kind == 2) b = 8'h5A;
            else                b = pkt[bi];
            for (int i = 0; i < 8; i++) begin
                if (b[i]) ones++;
                else begin lev ^= 1; ones = 0; end
                exp_sym[k++] = lev;
                if (ones == 6) begin lev ^= 1; ones = 0; exp_sym[k++] = lev; end
            end
        end
        exp_sym[k++] = 2;
        exp_sym[k++] = 2;
        exp_sym[k++] = 0;
        return k;
    endfunction

    // kind 3 = data and nak requested together; poke_at pulses req_ack; rx_at -2 = release-1
    task automatic run_pkt(input int kind_in, input int lreq, input logic [7:0] pat,
                           input logic [7:0] step, input logic [6:0] addr,
                           input string rq, input int poke_at, input int rx_at_in);
        int kind, n, nsym, rel, fcnt, bad_idx, s, mism, rel_seen, rx_at, idx;
        logic [6:0] a0;
        kind = (kind_in == 3) ? 0 : kind_in;
        n = (kind != 0) ? 2 : ((lreq < 2) ? 2 : ((lreq > 12) ? 12 : lreq));
        for (int i = 1; i < 16; i++) pkt[i] = pat + 8'(int'(step) * (i - 1));
        nsym  = build(kind, n);
        rel   = 1 + BITC * nsym;
        rx_at = (rx_at_in == -2) ? rel - 1 : rx_at_in;
        a0    = dev_addr;
        new_addr = addr;
        req_len  = 4'(lreq);
        req_data = (kind_in == 0 || kind_in == 3);
        req_ack  = (kind_in == 1);
        req_nak  = (kind_in == 2 || kind_in == 3);
        @(negedge clk);
        req_data = 1'b0; req_ack = 1'b0; req_nak = 1'b0;
        fcnt = 0; bad_idx = 0; s = 0; rel_seen = -1;
        while (s < CAPN) begin
            req_ack = 1'b0;
            rx_evt  = 1'b0;
            cap[s] = symcode();
            if (fetch_stb) begin
                if (fetch_idx != 4'(fcnt + 1)) bad_idx++;
                fcnt++;
            end
            if (!busy) begin rel_seen = s; break; end
            if (s == poke_at) req_ack = 1'b1;
            if (s == rx_at)   rx_evt  = 1'b1;
            s++;
            @(negedge clk);
        end
        check(rel_seen == rel, "R3 R8", {rq, " busy length"}, rel_seen, rel);
        check(cap[0] == 4, "R1", "prepared J with drivers off", cap[0], 4);
        check(cap[1] == 0, "R1", "drivers on at J", cap[1], 0);
        mism = 0;
        for (int j = 0; j < nsym; j++) begin
            idx = 1 + BITC * j + 5;
            if (idx >= CAPN || cap[idx] != exp_sym[j]) mism++;
        end
        check(mism == 0, rq, "line symbols mismatching", mism, 0);
        if (rel_seen >= 0)
            check(cap[rel_seen] == 5, "R7", "released lines", cap[rel_seen], 5);
        check(fcnt == ((kind == 0) ? n - 1 : 0) && bad_idx == 0,
              (kind == 0) ? "R5" : "R6", "fetch count", fcnt, (kind == 0) ? n - 1 : 0);
        check(dev_addr == ((kind == 0) ? addr : a0), "R9", "device address",
              dev_addr, (kind == 0) ? addr : a0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        string t;
        int kd, ln;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(!usb_oe && !usb_dp && !usb_dm, "R7", "lines after reset", {usb_oe, usb_dp, usb_dm}, 0);
        check(!busy, "R8", "busy after reset", busy, 0);
        check(dev_addr == 0, "R9", "address after reset", dev_addr, 0);
        check(!rx_pend, "R10", "pending after reset", rx_pend, 0);

        for (int v = 0; v < 8; v++) begin
            kd = int'(VEC[v][23:20]);
            ln = int'(VEC[v][19:16]);
            t = "R2";
            if (kd != 0) t = "R6";
            if (kd == 0 && (ln < 2 || ln > 12)) t = "R5";
            if (VEC[v][15:8] == 8'hFF || VEC[v][15:8] == 8'hFC) t = "R4";
            run_pkt(kd, ln, VEC[v][15:8], VEC[v][7:0], 7'(v * 9 + 3), t, -1, -1);
            repeat (2) @(negedge clk);
        end

        // R11: handshake request during a data packet is ignored
        run_pkt(0, 3, 8'h33, 8'h11, 7'h21, "R11", 40, -1);
        repeat (5) @(negedge clk);
        check(!busy, "R11", "no late start after ignored request", busy, 0);

        // R11: data wins over nak
        run_pkt(3, 2, 8'h5A, 8'h00, 7'h44, "R11", -1, -1);

        // R10: idle event sets pending, release clears it
        @(negedge clk);
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
        check(rx_pend, "R10", "pending after idle event", rx_pend, 1);
        run_pkt(1, 2, 8'h00, 8'h00, 7'h55, "R6", -1, -1);
        check(!rx_pend, "R10", "pending cleared at release", rx_pend, 0);

        // R10 R9: event in the release clock of a data packet, clear wins, address updates
        run_pkt(0, 2, 8'h0F, 8'h00, 7'h6A, "R2", -1, -2);
        check(!rx_pend, "R10", "clear wins at release", rx_pend, 0);
        @(negedge clk);
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
        check(rx_pend, "R10", "event after release sets", rx_pend, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule